// File: doc/BRIEF.md
# I2C Target Acknowledge Controller

This block decides, for the target side of an I2C serial engine, whether each byte on the bus is acknowledged. It also sets when that acknowledge is driven and when the clock is stretched. It takes a bus that has already been synchronised and reduced to one-cycle SCL rising and falling edge pulses, a sampled SDA level, and START/STOP pulses from a separate front end. From these it counts bits within each byte. The first byte after a START is decoded as a 7-bit address followed by a direction bit.

For the address byte the policy depends on what arrived. The block always acknowledges its own address. It acknowledges an extension code only when auto-acknowledge is enabled, and it never acknowledges any other address. Once selected as a receiver, it acknowledges each data byte according to the auto-acknowledge enable. A wait-timing select chooses whether SCL is held low after the eighth or the ninth falling edge of each byte, and a one-cycle release strobe ends the hold. When the block is the transmitter, it samples the ninth-clock SDA level and reports whether the bus master acknowledged.

Top module: `i2c_ack_ctrl`

## Requirements
- R1: After reset, START or STOP, the block releases SDA (`sda_low`=0) and SCL (`scl_hold`=0), and clears `xmit` and `ack_seen`. The bit counter returns to the start of an address byte.
- R2: If the 7 address bits (the first 7 bits received, MSB first) equal `own_addr`, `sda_low` is 1 from the cycle after the 8th SCL falling edge, whatever `ack_en` is.
- R3: If the address is neither `own_addr` nor an extension code, the block does not drive `sda_low` or `scl_hold` for that byte or for any later byte until the next START.
- R4: An address whose upper 4 bits are 0000 or whose upper 5 bits are 11110 is an extension code. It is acknowledged, and the block is selected, only if `ack_en` is 1 at the 8th falling edge.
- R5: `xmit` is loaded from the 8th bit of the first byte at its 8th falling edge. 1 means the target transmits and 0 means it receives.
- R6: With `wait_at_ninth`=1, a received data byte is acknowledged (`sda_low`=1) from the 8th falling edge exactly when `ack_en` is 1 at that edge. `scl_hold` rises the cycle after the 9th falling edge of every byte while selected.
- R7: With `wait_at_ninth`=0, `scl_hold` rises the cycle after the 8th falling edge while selected. During that hold on a received data byte, `sda_low` follows `ack_en` one cycle later. The value is frozen when the hold is released.
- R8: `wait_release` clears `scl_hold` on the next cycle. When no hold is active it changes no output.
- R9: While transmitting data bytes the block never drives `sda_low`. At the 9th SCL rising edge it sets `ack_seen` to 1 if `sda_in` is 0 and to 0 if `sda_in` is 1.
- R10: `sda_low` returns to 0 the cycle after the 9th SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | One-cycle START (or repeated START) pulse |
| bus_stop | input | 1 | One-cycle STOP pulse |
| scl_rise | input | 1 | One-cycle pulse on an SCL rising edge |
| scl_fall | input | 1 | One-cycle pulse on an SCL falling edge |
| sda_in | input | 1 | Synchronised SDA level |
| own_addr | input | ADDR_W | Programmable own address |
| ack_en | input | 1 | Auto-acknowledge enable |
| wait_at_ninth | input | 1 | 1: hold after 9th falling edge; 0: after 8th |
| wait_release | input | 1 | One-cycle strobe ending an SCL hold |
| sda_low | output | 1 | Pull SDA low (acknowledge) |
| scl_hold | output | 1 | Hold SCL low (wait) |
| xmit | output | 1 | Direction flag, 1 = target transmits |
| ack_seen | output | 1 | Acknowledge detected while transmitting |

## Verification
A wrong bit count or a stale selection shows up at the ports within one clock. The acknowledge or the hold then appears on the wrong edge, or on a byte that should be ignored. A behavioural model is compared with all four outputs on every cycle, so a slip is caught on the cycle it happens, not at the end of a transfer. Directed checks pin down the edge-exact points: the acknowledge after the 8th falling edge, the release after the 9th, the frozen enable at wait release, and the sampled master acknowledge.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;

    // Address prefixes that mark an extension code (general call / start
    // byte family and the 10-bit address family).
    localparam logic [3:0] EXT_LOW_PREFIX  = 4'b0000;
    localparam logic [4:0] EXT_HIGH_PREFIX = 5'b11110;

    // Registered state of the acknowledge policy.
    typedef struct packed {
        logic sel;       // addressed in the current transfer
        logic xmit;      // direction captured from the first byte
        logic sda_low;   // acknowledge drive
        logic scl_hold;  // clock stretch
        logic track;     // ack follows enable while held (8-clock wait)
        logic ack_seen;  // master acknowledge observed
    } ack_state_t;

endpackage

// File: rtl/i2c_ack_bitcnt.sv
module i2c_ack_bitcnt #(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 sda_in,
    output logic [BYTE_BITS-1:0] rx_byte,
    output logic                 first_byte,
    output logic                 byte_done,
    output logic                 ack_rise,
    output logic                 ack_fall
);
    localparam int CW = $clog2(BYTE_BITS + 2);
    localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_BITS);
    localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_BITS + 1);

    typedef struct packed {
        logic [CW-1:0]        cnt;
        logic                 first;
        logic [BYTE_BITS-1:0] shreg;
    } bc_state_t;

    bc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt   = '0;
            st_d.first = 1'b1;
            st_d.shreg = '0;
        end else begin
            if (scl_rise) begin
                if (st_q.cnt < LAST_BIT) begin
                    st_d.shreg = {st_q.shreg[BYTE_BITS-2:0], sda_in};
                    st_d.cnt   = st_q.cnt + 1'b1;
                end else if (st_q.cnt == LAST_BIT) begin
                    st_d.cnt = ACK_SLOT;
                end
            end
            if (scl_fall && st_q.cnt == ACK_SLOT) begin
                st_d.cnt   = '0;
                st_d.first = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.first <= 1'b1;
            st_q.shreg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_byte    = st_q.shreg;
    assign first_byte = st_q.first;
    assign byte_done  = !clr && scl_fall && (st_q.cnt == LAST_BIT);
    assign ack_rise   = !clr && scl_rise && (st_q.cnt == LAST_BIT);
    assign ack_fall   = !clr && scl_fall && (st_q.cnt == ACK_SLOT);

endmodule

// File: rtl/i2c_ack_addr_dec.sv
module i2c_ack_addr_dec
    import i2c_ack_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              match,
    output logic              ext_code,
    output logic              rw_bit
);
    logic [ADDR_W-1:0] addr;

    always_comb begin
        addr     = rx_byte[ADDR_W:1];
        rw_bit   = rx_byte[0];
        match    = (addr == own_addr);
        ext_code = (addr[ADDR_W-1 -: 4] == EXT_LOW_PREFIX) ||
                   (addr[ADDR_W-1 -: 5] == EXT_HIGH_PREFIX);
    end

endmodule

// File: rtl/i2c_ack_policy.sv
module i2c_ack_policy
    import i2c_ack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic byte_done,
    input  logic ack_rise,
    input  logic ack_fall,
    input  logic first_byte,
    input  logic match,
    input  logic ext_code,
    input  logic rw_bit,
    input  logic sda_in,
    input  logic ack_en,
    input  logic wait_at_ninth,
    input  logic wait_release,
    output logic sda_low,
    output logic scl_hold,
    output logic xmit,
    output logic ack_seen
);
    ack_state_t st_d, st_q;
    logic       addr_ok;

    always_comb begin
        st_d    = st_q;
        addr_ok = match || (ext_code && ack_en);
        if (clr) begin
            st_d = '0;
        end else begin
            // end of the eighth bit: decide the acknowledge
            if (byte_done) begin
                if (first_byte) begin
                    st_d.sel      = addr_ok;
                    st_d.xmit     = rw_bit;
                    st_d.sda_low  = addr_ok;
                    st_d.scl_hold = addr_ok && !wait_at_ninth;
                    st_d.track    = 1'b0;
                end else if (st_q.sel) begin
                    st_d.scl_hold = !wait_at_ninth;
                    if (!st_q.xmit) begin
                        st_d.sda_low = ack_en;
                        st_d.track   = !wait_at_ninth;
                    end
                end
            end
            // ninth rising edge: sample the master's acknowledge
            if (ack_rise && st_q.sel && st_q.xmit && !first_byte) begin
                st_d.ack_seen = !sda_in;
            end
            // ninth falling edge: release SDA, maybe start the late wait
            if (ack_fall) begin
                st_d.sda_low = 1'b0;
                st_d.track   = 1'b0;
                if (st_q.sel && wait_at_ninth) begin
                    st_d.scl_hold = 1'b1;
                end
            end
            // wait handling
            if (wait_release && st_q.scl_hold) begin
                st_d.scl_hold = 1'b0;
                st_d.track    = 1'b0;
            end else if (st_q.track && st_q.scl_hold) begin
                st_d.sda_low = ack_en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_low  = st_q.sda_low;
    assign scl_hold = st_q.scl_hold;
    assign xmit     = st_q.xmit;
    assign ack_seen = st_q.ack_seen;

endmodule

// File: rtl/i2c_ack_ctrl.sv
module i2c_ack_ctrl #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_en,
    input  logic              wait_at_ninth,
    input  logic              wait_release,
    output logic              sda_low,
    output logic              scl_hold,
    output logic              xmit,
    output logic              ack_seen
);
    localparam int BYTE_BITS = ADDR_W + 1;

    logic                 clr_w;
    logic [BYTE_BITS-1:0] rx_byte_w;
    logic                 first_w;
    logic                 byte_done_w;
    logic                 ack_rise_w;
    logic                 ack_fall_w;
    logic                 match_w;
    logic                 ext_w;
    logic                 rw_w;

    assign clr_w = bus_start || bus_stop;

    i2c_ack_bitcnt #(.BYTE_BITS(BYTE_BITS)) u_bitcnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_w),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_in     (sda_in),
        .rx_byte    (rx_byte_w),
        .first_byte (first_w),
        .byte_done  (byte_done_w),
        .ack_rise   (ack_rise_w),
        .ack_fall   (ack_fall_w)
    );

    i2c_ack_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .rx_byte  (rx_byte_w),
        .own_addr (own_addr),
        .match    (match_w),
        .ext_code (ext_w),
        .rw_bit   (rw_w)
    );

    i2c_ack_policy u_policy (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (clr_w),
        .byte_done     (byte_done_w),
        .ack_rise      (ack_rise_w),
        .ack_fall      (ack_fall_w),
        .first_byte    (first_w),
        .match         (match_w),
        .ext_code      (ext_w),
        .rw_bit        (rw_w),
        .sda_in        (sda_in),
        .ack_en        (ack_en),
        .wait_at_ninth (wait_at_ninth),
        .wait_release  (wait_release),
        .sda_low       (sda_low),
        .scl_hold      (scl_hold),
        .xmit          (xmit),
        .ack_seen      (ack_seen)
    );

endmodule

// File: rtl/i2c_ack_ctrl_chk.sv
module i2c_ack_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic byte_done,
    input logic ack_fall,
    input logic first_byte,
    input logic match,
    input logic ext_code,
    input logic rx_lsb,
    input logic wait_release,
    input logic sda_low,
    input logic scl_hold,
    input logic xmit,
    input logic ack_seen
);
    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!sda_low && !scl_hold && !ack_seen && !xmit)); // R1

    AST_OWN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && first_byte && match && !clr) |=> sda_low); // R2

    AST_NOSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && first_byte && !match && !ext_code && !clr) |=> (!sda_low && !scl_hold)); // R3

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && first_byte && !clr) |=> (xmit == $past(rx_lsb))); // R5

    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold && wait_release && !clr) |=> !scl_hold); // R8

    AST_TX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (xmit && !first_byte) |-> !sda_low); // R9

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fall && !clr) |=> !sda_low); // R10

endmodule

bind i2c_ack_ctrl i2c_ack_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr_w),
    .byte_done    (byte_done_w),
    .ack_fall     (ack_fall_w),
    .first_byte   (first_w),
    .match        (match_w),
    .ext_code     (ext_w),
    .rx_lsb       (rx_byte_w[0]),
    .wait_release (wait_release),
    .sda_low      (sda_low),
    .scl_hold     (scl_hold),
    .xmit         (xmit),
    .ack_seen     (ack_seen)
);

// File: tb/i2c_ack_ctrl_tb.sv
module i2c_ack_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0, bus_stop = 1'b0;
    logic       scl_rise = 1'b0, scl_fall = 1'b0, sda_in = 1'b1;
    logic [6:0] own_addr = 7'h2A;
    logic       ack_en = 1'b0, wait_at_ninth = 1'b1, wait_release = 1'b0;
    logic       sda_low, scl_hold, xmit, ack_seen;

    int total = 0;
    int bad = 0;
    int cyc_n = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    i2c_ack_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
        .own_addr(own_addr), .ack_en(ack_en), .wait_at_ninth(wait_at_ninth),
        .wait_release(wait_release), .sda_low(sda_low), .scl_hold(scl_hold),
        .xmit(xmit), .ack_seen(ack_seen)
    );

    // ---------------- behavioural reference model ----------------
    int  m_pos;          // rising edges seen in current byte (0..9)
    bit  m_first, m_sel, m_xmit, m_sda, m_hold, m_follow, m_seen;
    bit  bits[$];

    always @(posedge clk) begin
        if (!rst_n || bus_start || bus_stop) begin
            m_pos = 0; m_first = 1; m_sel = 0; m_xmit = 0; m_sda = 0;
            m_hold = 0; m_follow = 0; m_seen = 0; bits.delete();
        end else begin
            if (scl_rise) begin
                if (m_pos < 8) begin
                    bits.push_back(sda_in);
                    m_pos++;
                end else if (m_pos == 8) begin
                    if (m_sel && m_xmit && !m_first) m_seen = !sda_in;
                    m_pos = 9;
                end
            end
            if (scl_fall && m_pos == 9) begin
                m_sda = 0; m_follow = 0;
                if (m_sel && wait_at_ninth) m_hold = 1;
                m_pos = 0; m_first = 0;
            end else if (scl_fall && m_pos == 8) begin
                int a;
                bit ext;
                a = 0;
                for (int i = 0; i < 7; i++) a = a * 2 + int'(bits[i]);
                ext = ((a / 8) == 0) || ((a / 4) == 30);
                if (m_first) begin
                    m_sel = (a == int'(own_addr)) || (ext && ack_en);
                    m_xmit = bits[7];
                    m_sda = m_sel;
                    m_hold = m_sel && !wait_at_ninth;
                    m_follow = 0;
                end else if (m_sel) begin
                    m_hold = !wait_at_ninth;
                    if (!m_xmit) begin
                        m_sda = ack_en;
                        m_follow = !wait_at_ninth;
                    end
                end
                bits.delete();
            end
            if (wait_release && m_hold) begin
                m_hold = 0; m_follow = 0;
            end else if (m_follow && m_hold) begin
                m_sda = ack_en;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if ({sda_low, scl_hold, xmit, ack_seen} !== {m_sda, m_hold, m_xmit, m_seen}) begin
                bad++;
                $display("FAIL MODEL t=%0t act=%b%b%b%b exp=%b%b%b%b", $time,
                         sda_low, scl_hold, xmit, ack_seen, m_sda, m_hold, m_xmit, m_seen);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 50000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=%0d exp<=50000", cyc_n);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0; @(negedge clk);
    endtask

    task automatic pulse_stop();
        @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0; @(negedge clk);
    endtask

    task automatic clk_rise(input logic b);
        sda_in = b; scl_rise = 1; @(negedge clk); scl_rise = 0; @(negedge clk);
    endtask

    task automatic clk_fall();
        scl_fall = 1; @(negedge clk); scl_fall = 0; @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            clk_rise(b[i]);
            clk_fall();
        end
    endtask

    task automatic release_wait();
        wait_release = 1; @(negedge clk); wait_release = 0; @(negedge clk);
    endtask

    initial begin
        idle(3);
        chk("R1 reset sda_low", sda_low, 1'b0);
        chk("R1 reset scl_hold", scl_hold, 1'b0);
        rst_n = 1;
        idle(2);

        // own address, write, 9-clock wait, enable off
        pulse_start();
        wait_at_ninth = 1; ack_en = 0;
        send_byte({7'h2A, 1'b0});
        chk("R2 own address acked with enable off", sda_low, 1'b1);
        chk("R5 direction receive", xmit, 1'b0);
        chk("R6 no hold before ninth fall", scl_hold, 1'b0);
        clk_rise(1'b0);
        chk("R2 ack held through ninth clock", sda_low, 1'b1);
        clk_fall();
        chk("R10 ack released after ninth fall", sda_low, 1'b0);
        chk("R6 hold after ninth fall", scl_hold, 1'b1);
        release_wait();
        chk("R8 release clears hold", scl_hold, 1'b0);

        // data byte, enable off -> NACK
        send_byte(8'h5C);
        chk("R6 data NACK with enable off", sda_low, 1'b0);
        clk_rise(1'b1); clk_fall(); release_wait();

        // data byte, enable on -> ACK
        ack_en = 1;
        send_byte(8'hA3);
        chk("R6 data ACK with enable on", sda_low, 1'b1);
        clk_rise(1'b0); clk_fall();
        chk("R6 hold after ninth fall again", scl_hold, 1'b1);
        release_wait();

        // 8-clock wait: enable follows during hold, frozen at release
        wait_at_ninth = 0; ack_en = 0;
        send_byte(8'h11);
        chk("R7 hold after eighth fall", scl_hold, 1'b1);
        chk("R7 no ack yet", sda_low, 1'b0);
        ack_en = 1; idle(2);
        chk("R7 ack follows enable during hold", sda_low, 1'b1);
        release_wait();
        chk("R8 hold released", scl_hold, 1'b0);
        ack_en = 0; idle(2);
        chk("R7 ack frozen after release", sda_low, 1'b1);
        clk_rise(1'b0); clk_fall();
        chk("R10 release in 8-clock wait", sda_low, 1'b0);

        // release strobe with no hold does nothing
        release_wait();
        chk("R8 stray release keeps hold off", scl_hold, 1'b0);
        chk("R8 stray release keeps sda", sda_low, 1'b0);

        pulse_stop();
        chk("R1 stop clears direction", xmit, 1'b0);

        // non-matching address
        wait_at_ninth = 1; ack_en = 1;
        pulse_start();
        send_byte({7'h55, 1'b0});
        chk("R3 foreign address NACK", sda_low, 1'b0);
        clk_rise(1'b1); clk_fall();
        chk("R3 foreign address no hold", scl_hold, 1'b0);
        send_byte(8'hFF);
        chk("R3 foreign data NACK", sda_low, 1'b0);
        clk_rise(1'b1); clk_fall();
        chk("R3 foreign data no hold", scl_hold, 1'b0);

        // extension code with enable off, then on
        ack_en = 0;
        pulse_start();
        send_byte({7'b1111000, 1'b0});
        chk("R4 extension code NACK with enable off", sda_low, 1'b0);
        ack_en = 1;
        pulse_start();
        send_byte({7'b0000001, 1'b0});
        chk("R4 extension code ACK with enable on", sda_low, 1'b1);
        clk_rise(1'b0); clk_fall();

        // read transfer
        pulse_start();
        chk("R1 start clears hold", scl_hold, 1'b0);
        send_byte({7'h2A, 1'b1});
        chk("R5 direction transmit", xmit, 1'b1);
        chk("R2 own address acked on read", sda_low, 1'b1);
        clk_rise(1'b0); clk_fall(); release_wait();
        send_byte(8'h96);
        chk("R9 no drive while transmitting", sda_low, 1'b0);
        clk_rise(1'b0);
        chk("R9 master ack seen", ack_seen, 1'b1);
        clk_fall(); release_wait();
        send_byte(8'h3C);
        clk_rise(1'b1);
        chk("R9 master NACK clears flag", ack_seen, 1'b0);
        clk_fall(); release_wait();
        send_byte(8'h01);
        clk_rise(1'b0); clk_fall();
        chk("R9 ack seen again", ack_seen, 1'b1);
        pulse_start();
        chk("R1 start clears ack_seen", ack_seen, 1'b0);

        idle(3);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule